// File: doc/BRIEF.md
# Credit-Driven Packet Link Controller

This block sits between a node's local word streams and the point-to-point link toward its neighbour in a chain of nodes. Outgoing data packets, of up to `PKT_WORDS` words each, are forwarded to the link only while the node holds a credit. Each credit stands for one packet slot that is free in the neighbour's receive buffer. Incoming data packets are stored in a local receive buffer sized for `RX_SLOTS` whole packets. Each time the consumer drains the last word of a stored packet, one credit word goes back over the same link. The transmitter never waits on anything beyond its direct neighbour, so a stall spreads back one node at a time. A separate single-word control channel shares the link but needs no credits. It is therefore never held behind data that is starved of credits.

Every word on the link carries a 2-bit kind sideband: 01 for data, 10 for credit, 11 for control, 00 for idle. All stream ports follow valid/ready rules. A transfer happens on a rising clock edge where both valid and ready are high. A source that raises valid keeps its payload unchanged until that transfer. Ready may depend on valid within the same cycle. The outgoing link is driven combinationally from the selected source. When `lo_ready` is low, the selection is frozen, so the word on offer cannot change or be pre-empted. Incoming link words are steered by kind. Credit words are always accepted. Data words are accepted while the receive buffer has room. Control words are accepted when `co_ready` is high.

Top module: `credlink_ctrl`

## Requirements
- R1: During and right after reset, `lo_valid`, `m_valid`, `co_valid` and `cred_err` are 0, and the transmit credit count equals `REMOTE_SLOTS`.
- R2: A new outgoing data packet (kind 01) may start only while the credit count is non-zero. Each packet start consumes exactly one credit. With no credit left, `lo_valid` and `s_ready` stay low for pending data.
- R3: An incoming credit word (kind 10) is accepted in the cycle it is offered (`li_ready` high), and it allows exactly one more packet to start.
- R4: Once the first word of a data packet has been sent, only words of that packet (kind 01) go out until the word marked `lo_last`, whatever else is pending.
- R5: At a message boundary the outgoing link serves, in priority order: a pending credit word, then a control word, then a new data packet.
- R6: Each time the last word of a stored packet leaves the receive buffer, exactly one credit word is sent: kind 10, payload 0, `lo_last` 1.
- R7: Control words pass in both directions regardless of credits or receive-buffer fill. An outgoing control word (`c_valid`) is sent as kind 11 with `lo_last` 1 even at zero credits. An incoming kind-11 word appears on `co_data` and is accepted when `co_ready` is high, even while the receive buffer is full.
- R8: A credit word that arrives while the count already equals `REMOTE_SLOTS` (with no packet starting in that cycle) leaves the count unchanged and sets `cred_err`. `cred_err` stays 1 until reset.
- R9: While `lo_valid` is high and `lo_ready` is low, `lo_kind`, `lo_data` and `lo_last` stay unchanged, and the offered word is not replaced by a higher-priority request.
- R10: The receive buffer holds `RX_SLOTS*PKT_WORDS` data words and delivers them in arrival order with their last flags. When it is full, `li_ready` is low for a data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_valid | input | 1 | Outgoing data word valid |
| s_ready | output | 1 | Outgoing data word accepted |
| s_data | input | WORD_W | Outgoing data word |
| s_last | input | 1 | Last word of outgoing packet |
| c_valid | input | 1 | Outgoing control word valid |
| c_ready | output | 1 | Outgoing control word accepted |
| c_data | input | WORD_W | Outgoing control word |
| lo_valid | output | 1 | Link transmit word valid |
| lo_ready | input | 1 | Link transmit word accepted |
| lo_data | output | WORD_W | Link transmit word |
| lo_kind | output | 2 | Link transmit word kind |
| lo_last | output | 1 | Last word of transmitted message |
| li_valid | input | 1 | Link receive word valid |
| li_ready | output | 1 | Link receive word accepted |
| li_data | input | WORD_W | Link receive word |
| li_kind | input | 2 | Link receive word kind |
| li_last | input | 1 | Last word of received message |
| m_valid | output | 1 | Received data word valid |
| m_ready | input | 1 | Received data word taken |
| m_data | output | WORD_W | Received data word |
| m_last | output | 1 | Last word of received packet |
| co_valid | output | 1 | Received control word valid |
| co_ready | input | 1 | Received control word taken |
| co_data | output | WORD_W | Received control word |
| cred_err | output | 1 | Sticky credit overflow flag |

## Verification
The bench builds the block with `PKT_WORDS=4`, `RX_SLOTS=2` and `REMOTE_SLOTS=2`. With these values, two short packets use up every credit, so the starved state is reached quickly. The same values let eight data words fill the receive buffer completely, so the full-buffer refusal and the control bypass beside it can be exercised. Because the credit ceiling is only two, the count can be pushed back to its maximum and then past it in a few cycles, which is how the sticky overflow flag and the saturated count are checked.

// File: rtl/credlink_pkg.sv
package credlink_pkg;

  // link word kind sideband
  typedef enum logic [1:0] {
    KIND_IDLE = 2'b00,
    KIND_DATA = 2'b01,
    KIND_CRED = 2'b10,
    KIND_CTRL = 2'b11
  } kind_e;

  // transmit source selection
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CRED,
    SEL_CTRL,
    SEL_DATA
  } sel_e;

endpackage

// File: rtl/credlink_txcredit.sv
module credlink_txcredit #(
  parameter int unsigned MAX_CRED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cred_in,
  input  logic pkt_start,
  output logic have_cred,
  output logic err_o
);
  localparam int unsigned CW = $clog2(MAX_CRED + 1);
  localparam logic [CW-1:0] MAXV = CW'(MAX_CRED);

  logic [CW-1:0] cnt;
  logic          err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= MAXV;
      err_q <= 1'b0;
    end else begin
      unique case ({cred_in, pkt_start})
        2'b10: begin
          if (cnt == MAXV) err_q <= 1'b1;
          else             cnt   <= cnt + 1'b1;
        end
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign have_cred = (cnt != '0);
  assign err_o     = err_q;

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAXV);
  a_r2_start_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> cnt != '0);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_in && !pkt_start && cnt == MAXV) |=> (cnt == MAXV && err_q));

endmodule

// File: rtl/credlink_rxbuf.sv
module credlink_rxbuf #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         slot_free
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LASTIDX = AW'(DEPTH - 1);

  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LASTIDX) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign {out_last, out_data} = mem[rp];
  assign slot_free = pop && out_last;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {in_last, in_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      unique case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  a_r10_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r10_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !pop) |=> cnt == CW'(DEPTH));

endmodule

// File: rtl/credlink_arb.sv
module credlink_arb
  import credlink_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned SLOTS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         s_last,
  input  logic         c_valid,
  output logic         c_ready,
  input  logic [W-1:0] c_data,
  input  logic         have_cred,
  input  logic         slot_free,
  output logic         pkt_start,
  output logic         lo_valid,
  input  logic         lo_ready,
  output logic [W-1:0] lo_data,
  output logic [1:0]   lo_kind,
  output logic         lo_last
);
  localparam int unsigned PW = $clog2(SLOTS + 1);

  logic [PW-1:0] pend;
  logic          in_pkt, hold_q, go, cred_go;
  sel_e          sel, sel_q;
  kind_e         kind;

  // source selection; frozen while the offered word waits
  always_comb begin
    if (hold_q)                     sel = sel_q;
    else if (in_pkt)                sel = s_valid ? SEL_DATA : SEL_NONE;
    else if (pend != '0)            sel = SEL_CRED;
    else if (c_valid)               sel = SEL_CTRL;
    else if (s_valid && have_cred)  sel = SEL_DATA;
    else                            sel = SEL_NONE;
  end

  always_comb begin
    lo_data = '0;
    lo_last = 1'b0;
    kind    = KIND_IDLE;
    unique case (sel)
      SEL_CRED: begin kind = KIND_CRED; lo_last = 1'b1; end
      SEL_CTRL: begin kind = KIND_CTRL; lo_data = c_data; lo_last = 1'b1; end
      SEL_DATA: begin kind = KIND_DATA; lo_data = s_data; lo_last = s_last; end
      default: ;
    endcase
  end

  assign lo_kind   = kind;
  assign lo_valid  = (sel != SEL_NONE);
  assign go        = lo_valid && lo_ready;
  assign s_ready   = lo_ready && (sel == SEL_DATA);
  assign c_ready   = lo_ready && (sel == SEL_CTRL);
  assign cred_go   = go && (sel == SEL_CRED);
  assign pkt_start = go && (sel == SEL_DATA) && !in_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      in_pkt <= 1'b0;
      hold_q <= 1'b0;
      sel_q  <= SEL_NONE;
    end else begin
      hold_q <= lo_valid && !lo_ready;
      sel_q  <= sel;
      if (go && sel == SEL_DATA) in_pkt <= !s_last;
      unique case ({slot_free, cred_go})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: ;
      endcase
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_valid && !lo_ready) |=> (lo_valid && lo_kind == $past(lo_kind)
      && lo_data == $past(lo_data) && lo_last == $past(lo_last)));
  a_r4_no_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && lo_valid) |-> lo_kind == KIND_DATA);
  a_r6_cred_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_valid && lo_kind == KIND_CRED) |-> pend != '0);
  a_r6_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(SLOTS));
  a_r5_ctrl_after_cred: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_valid && lo_kind == KIND_CTRL && !hold_q) |-> pend == '0);
  a_r6_one_credit_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && !cred_go) |=> pend == $past(pend) + 1'b1);

endmodule

// File: rtl/credlink_ctrl.sv
module credlink_ctrl
  import credlink_pkg::*;
#(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned PKT_WORDS    = 16,
  parameter int unsigned RX_SLOTS     = 4,
  parameter int unsigned REMOTE_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_last,
  input  logic              c_valid,
  output logic              c_ready,
  input  logic [WORD_W-1:0] c_data,
  output logic              lo_valid,
  input  logic              lo_ready,
  output logic [WORD_W-1:0] lo_data,
  output logic [1:0]        lo_kind,
  output logic              lo_last,
  input  logic              li_valid,
  output logic              li_ready,
  input  logic [WORD_W-1:0] li_data,
  input  logic [1:0]        li_kind,
  input  logic              li_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              m_last,
  output logic              co_valid,
  input  logic              co_ready,
  output logic [WORD_W-1:0] co_data,
  output logic              cred_err
);
  localparam int unsigned RX_DEPTH = RX_SLOTS * PKT_WORDS;

  logic have_cred, pkt_start, slot_free;
  logic rx_valid, rx_ready, cred_in;

  // steer incoming link words by kind
  assign rx_valid = li_valid && (li_kind == KIND_DATA);
  assign cred_in  = li_valid && (li_kind == KIND_CRED);
  assign co_valid = li_valid && (li_kind == KIND_CTRL);
  assign co_data  = li_data;

  always_comb begin
    unique case (li_kind)
      KIND_DATA: li_ready = rx_ready;
      KIND_CTRL: li_ready = co_ready;
      default:   li_ready = 1'b1;
    endcase
  end

  credlink_txcredit #(.MAX_CRED(REMOTE_SLOTS)) u_txcredit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cred_in   (cred_in),
    .pkt_start (pkt_start),
    .have_cred (have_cred),
    .err_o     (cred_err)
  );

  credlink_rxbuf #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_valid),
    .in_ready  (rx_ready),
    .in_data   (li_data),
    .in_last   (li_last),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (m_data),
    .out_last  (m_last),
    .slot_free (slot_free)
  );

  credlink_arb #(.W(WORD_W), .SLOTS(RX_SLOTS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .s_last    (s_last),
    .c_valid   (c_valid),
    .c_ready   (c_ready),
    .c_data    (c_data),
    .have_cred (have_cred),
    .slot_free (slot_free),
    .pkt_start (pkt_start),
    .lo_valid  (lo_valid),
    .lo_ready  (lo_ready),
    .lo_data   (lo_data),
    .lo_kind   (lo_kind),
    .lo_last   (lo_last)
  );

  a_r7_ctrl_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (li_valid && li_kind == KIND_CTRL && co_ready) |-> li_ready);
  a_r3_credit_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cred_in |-> li_ready);

endmodule

// File: tb/test_credlink_ctrl.sv
module test_credlink_ctrl;
  localparam int unsigned W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 0, s_last = 0, c_valid = 0, lo_ready = 1;
  logic li_valid = 0, li_last = 0, m_ready = 0, co_ready = 1;
  logic [W-1:0] s_data = '0, c_data = '0, li_data = '0;
  logic [1:0]   li_kind = 2'b00;
  logic s_ready, c_ready, lo_valid, lo_last, li_ready, m_valid, m_last;
  logic co_valid, cred_err;
  logic [W-1:0] lo_data, m_data, co_data;
  logic [1:0]   lo_kind;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  credlink_ctrl #(.WORD_W(W), .PKT_WORDS(4), .RX_SLOTS(2), .REMOTE_SLOTS(2)) i_credlink_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_data(lo_data), .lo_kind(lo_kind), .lo_last(lo_last),
    .li_valid(li_valid), .li_ready(li_ready), .li_data(li_data), .li_kind(li_kind), .li_last(li_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .co_valid(co_valid), .co_ready(co_ready), .co_data(co_data), .cred_err(cred_err)
  );

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // one data packet through the link, checking every word (R4)
  task automatic send_pkt(input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lo_ready = 1; s_valid = 1; s_data = base + W'(i); s_last = (i == n - 1);
      #1;
      chk(lo_valid && lo_kind == 2'b01 && lo_data == base + W'(i) && lo_last == (i == n - 1) && s_ready,
          "R4 packet word", lo_data, base + W'(i));
    end
    @(posedge clk);
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic inject_credit();
    @(negedge clk);
    li_valid = 1; li_kind = 2'b10; li_data = '0; li_last = 1;
    #1 chk(li_ready, "R3 credit accepted", W'(li_ready), 1);
    @(posedge clk);
    @(negedge clk);
    li_valid = 0; li_kind = 2'b00; li_last = 0;
  endtask

  task automatic rx_push(input int n, input logic [W-1:0] base, input int plen);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      li_valid = 1; li_kind = 2'b01; li_data = base + W'(i); li_last = ((i % plen) == plen - 1);
      #1 chk(li_ready, "R10 rx space", W'(li_ready), 1);
      @(posedge clk);
    end
    @(negedge clk);
    li_valid = 0; li_kind = 2'b00; li_last = 0;
  endtask

  task automatic rx_pop(input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_ready = 1;
      #1 chk(m_valid && m_data == base + W'(i) && m_last == (i == n - 1),
             "R10 rx order", m_data, base + W'(i));
      @(posedge clk);
    end
    @(negedge clk);
    m_ready = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!lo_valid, "R1 lo_valid", W'(lo_valid), 0);
    chk(!m_valid, "R1 m_valid", W'(m_valid), 0);
    chk(!co_valid, "R1 co_valid", W'(co_valid), 0);
    chk(!cred_err, "R1 cred_err", W'(cred_err), 0);
  endtask

  task automatic t_exhaust();
    send_pkt(4, 32'h100);
    send_pkt(4, 32'h200);
    @(negedge clk);
    s_valid = 1; s_data = 32'h300; s_last = 0; lo_ready = 1;
    for (int k = 0; k < 3; k++) begin
      #1 chk(!lo_valid && !s_ready, "R2 starved", W'(lo_valid), 0);
      @(negedge clk);
    end
    c_valid = 1; c_data = 32'hC001;
    #1 chk(lo_valid && lo_kind == 2'b11 && lo_data == 32'hC001 && lo_last && c_ready,
           "R7 ctrl at zero credit", lo_data, 32'hC001);
    @(posedge clk);
    @(negedge clk);
    c_valid = 0;
    #1 chk(!lo_valid, "R2 still starved", W'(lo_valid), 0);
    lo_ready = 0;
    inject_credit();
    #1 chk(lo_valid && lo_kind == 2'b01 && lo_data == 32'h300, "R3 credit releases packet", lo_data, 32'h300);
    send_pkt(4, 32'h300);
  endtask

  task automatic t_priority();
    inject_credit();
    lo_ready = 0;
    rx_push(4, 32'h400, 4);
    rx_pop(4, 32'h400);
    #1 chk(lo_valid && lo_kind == 2'b10 && lo_data == '0 && lo_last, "R6 credit word", W'(lo_kind), 2);
    c_valid = 1; c_data = 32'hC002; s_valid = 1; s_data = 32'h500; s_last = 0; lo_ready = 1;
    #1 chk(lo_kind == 2'b10, "R5 credit first", W'(lo_kind), 2);
    @(posedge clk);
    @(negedge clk); #1;
    chk(lo_valid && lo_kind == 2'b11 && lo_data == 32'hC002, "R5 ctrl second", W'(lo_kind), 3);
    @(posedge clk);
    @(negedge clk);
    c_valid = 0; lo_ready = 0;
    #1 chk(lo_valid && lo_kind == 2'b01 && lo_data == 32'h500, "R5 data third", W'(lo_kind), 1);
    send_pkt(2, 32'h500);
  endtask

  task automatic t_midpkt();
    inject_credit();
    @(negedge clk);
    s_valid = 1; s_data = 32'h600; s_last = 0; lo_ready = 1;
    #1 chk(lo_kind == 2'b01 && lo_data == 32'h600, "R4 first word", lo_data, 32'h600);
    @(posedge clk);
    @(negedge clk);
    s_data = 32'h601; c_valid = 1; c_data = 32'hC003;
    #1 chk(lo_kind == 2'b01 && lo_data == 32'h601 && !c_ready, "R4 ctrl waits mid packet", W'(lo_kind), 1);
    @(posedge clk);
    @(negedge clk);
    s_data = 32'h602; s_last = 1;
    #1 chk(lo_kind == 2'b01 && lo_data == 32'h602 && lo_last, "R4 last word", lo_data, 32'h602);
    @(posedge clk);
    @(negedge clk);
    s_valid = 0; s_last = 0;
    #1 chk(lo_valid && lo_kind == 2'b11 && lo_data == 32'hC003, "R4 ctrl after packet", lo_data, 32'hC003);
    @(posedge clk);
    @(negedge clk);
    c_valid = 0;
  endtask

  task automatic t_stall();
    inject_credit();
    @(negedge clk);
    lo_ready = 0; s_valid = 1; s_data = 32'h700; s_last = 1;
    #1 chk(lo_valid && lo_kind == 2'b01 && lo_data == 32'h700, "R9 offered", lo_data, 32'h700);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      c_valid = 1; c_data = 32'hC004;
      #1 chk(lo_valid && lo_kind == 2'b01 && lo_data == 32'h700 && lo_last && !s_ready && !c_ready,
             "R9 held under stall", lo_data, 32'h700);
    end
    @(negedge clk);
    lo_ready = 1;
    #1 chk(lo_kind == 2'b01 && lo_data == 32'h700 && s_ready, "R9 released", lo_data, 32'h700);
    @(posedge clk);
    @(negedge clk);
    s_valid = 0; s_last = 0;
    #1 chk(lo_valid && lo_kind == 2'b11 && lo_data == 32'hC004, "R9 ctrl follows", lo_data, 32'hC004);
    @(posedge clk);
    @(negedge clk);
    c_valid = 0;
  endtask

  task automatic t_rxfull();
    lo_ready = 0;
    rx_push(8, 32'h800, 4);
    li_valid = 1; li_kind = 2'b01; li_data = 32'h8FF; li_last = 0;
    #1 chk(!li_ready, "R10 full refuses data", W'(li_ready), 0);
    @(negedge clk);
    li_kind = 2'b11; li_data = 32'hC005; li_last = 1; co_ready = 1;
    #1 chk(li_ready && co_valid && co_data == 32'hC005, "R7 ctrl in while full", co_data, 32'hC005);
    @(posedge clk);
    @(negedge clk);
    li_valid = 0; li_kind = 2'b00; li_last = 0;
    for (int p = 0; p < 2; p++) begin
      rx_pop(4, 32'h800 + W'(4 * p));
      #1 chk(lo_valid && lo_kind == 2'b10 && lo_last && lo_data == '0, "R6 credit per slot", W'(lo_kind), 2);
      @(negedge clk);
      lo_ready = 1;
      #1 chk(lo_kind == 2'b10, "R6 credit held", W'(lo_kind), 2);
      @(posedge clk);
      @(negedge clk); #1;
      chk(!lo_valid, "R6 exactly one credit", W'(lo_valid), 0);
      lo_ready = 0;
    end
    lo_ready = 1;
  endtask

  task automatic t_err();
    inject_credit();
    inject_credit();
    #1 chk(!cred_err, "R8 no error at max", W'(cred_err), 0);
    inject_credit();
    #1 chk(cred_err, "R8 overflow flagged", W'(cred_err), 1);
    send_pkt(1, 32'h900);
    send_pkt(1, 32'h901);
    @(negedge clk);
    s_valid = 1; s_data = 32'h902; s_last = 1;
    #1 chk(!lo_valid, "R8 count stayed at max", W'(lo_valid), 0);
    chk(cred_err, "R8 sticky", W'(cred_err), 1);
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_exhaust();
    t_priority();
    t_midpkt();
    t_stall();
    t_rxfull();
    t_err();
    done = 1;
    finish_run();
  end

  initial begin
    #2000000;
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      finish_run();
    end
  end

endmodule